// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block receives asynchronous serial characters on a single line. It samples the line on a tick that runs at sixteen times the bit rate, checks a low start bit at its midpoint, then collects 5 to 8 data bits, an optional even or odd parity bit and one or two stop bits. Every finished character is stored in a queue together with four status flags: break, overrun, parity error and framing error. A single read therefore returns the character and its own status as one 12-bit word.

The queue holds 16 entries when queueing is enabled. When queueing is disabled it holds a single character. Software reads until the empty flag rises. Two interrupt requests are raised. The level request asserts when the queue reaches half full, or as soon as it holds any character in single-entry mode. The idle request asserts when characters are waiting and the line has been quiet for 32 bit periods.

Top module: `uart_rx_efifo`

## Requirements
- R1: A read word carries the character in bits 7:0 (unused upper data bits are 0), the framing error flag in bit 8, the parity error flag in bit 9, the overrun flag in bit 10 and the break flag in bit 11.
- R2: `cfg_wlen` selects the number of data bits (00 = 5, 01 = 6, 10 = 7, 11 = 8), sent least significant bit first. `cfg_par_en` = 1 adds a parity bit and `cfg_par_even` = 1 selects even parity (0 selects odd). `cfg_stop2` = 1 expects two stop bits.
- R3: A start bit is confirmed only if the line is still low on the 8th tick after the falling edge. A shorter low pulse stores nothing, and the receiver returns to idle.
- R4: Bit 9 is set when the parity bit does not match the selected parity over the data bits. Bit 8 is set when any stop bit is sampled low.
- R5: A frame in which every sample, stop bits included, is low is stored as exactly one word with only bit 11 set (data 0, bits 9:8 clear). The receiver then waits for the line to return high before it looks for a new start bit.
- R6: With `cfg_fifo_en` = 1 up to 16 words are kept and read back in arrival order. With `cfg_fifo_en` = 0 only one word is kept.
- R7: A character that completes while the queue is full is discarded, and bit 10 is set in the most recently stored word.
- R8: A one-cycle `rd_en` while the queue is not empty places the oldest word on `rd_word` after the next clock edge and removes it. A `rd_en` while the queue is empty leaves `rd_word` and the queue unchanged.
- R9: `rx_empty` is 1 exactly when no word is stored.
- R10: `irq_rx` is 1 when at least 8 words are stored and `cfg_fifo_en` = 1, or when at least 1 word is stored and `cfg_fifo_en` = 0.
- R11: `irq_tmo` asserts once words are stored and 512 ticks (32 bit periods) pass with no character completing and no read. A read or a completed character clears it.
- R12: After reset the queue is empty, `irq_rx` and `irq_tmo` are 0 and `rd_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Serial input line, idle high |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| cfg_wlen | input | 2 | Data bit count select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity when 1, odd when 0 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_fifo_en | input | 1 | 16-entry queue when 1, single entry when 0 |
| rd_en | input | 1 | Read strobe |
| rd_word | output | 12 | Last word read: status in 11:8, character in 7:0 |
| rx_empty | output | 1 | No word stored |
| irq_rx | output | 1 | Receive level request |
| irq_tmo | output | 1 | Receive idle timeout request |

## Verification
A character is stored in the middle of its last stop bit. The line passes through two synchronizer flops, and the 16x tick can sit up to four clocks away from the edge, so the bench checks the queue only after the whole stop bit has been driven and some idle time has passed. A read word is due on the clock edge that samples `rd_en`, so the bench raises `rd_en` for one cycle and samples `rd_word` on the following falling edge. `rx_empty` and `irq_rx` follow the stored count in the same cycle. The 512-tick timeout is checked with a margin of more than 50 ticks on each side, to allow for the unknown position of the storing edge inside the stop bit.

// File: rtl/uartrx_pkg.sv
package uartrx_pkg;
  localparam int WORD_W = 12;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_e;

  typedef struct packed {
    logic       brk;
    logic       ovr;
    logic       perr;
    logic       ferr;
    logic [7:0] data;
  } rx_word_t;
endpackage

// File: rtl/uartrx_frame.sv
module uartrx_frame
  import uartrx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       stop2,
  output logic       push,
  output rx_word_t   word
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic       sync_a, line_s;
  rx_state_e  state;
  logic [CW-1:0] cnt;
  logic [2:0] bidx;
  logic [7:0] data;
  logic       par_acc, all_low, frm, stop_left;

  // Two-flop synchronizer on the asynchronous line.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b1;
      line_s <= 1'b1;
    end else begin
      sync_a <= line;
      line_s <= sync_a;
    end
  end

  logic samp, low_now, fin_ferr, fin_all, fin_perr;
  assign samp     = tick && (cnt == LAST);
  assign low_now  = !line_s;
  assign fin_ferr = frm | low_now;
  assign fin_all  = all_low & low_now;
  assign fin_perr = par_en & (par_acc == par_even);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt <= '0; bidx <= '0; data <= '0;
      par_acc <= 1'b0; all_low <= 1'b0; frm <= 1'b0; stop_left <= 1'b0;
      push <= 1'b0;
      word <= '0;
    end else begin
      push <= 1'b0;
      case (state)
        S_IDLE: if (low_now) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: if (tick) begin
          if (cnt == MID) begin
            if (!low_now) state <= S_IDLE;        // glitch
            else begin
              state <= S_DATA; cnt <= '0; bidx <= '0; data <= '0;
              par_acc <= 1'b0; all_low <= 1'b1; frm <= 1'b0;
              stop_left <= stop2;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick) begin
          cnt <= cnt + 1'b1;
          if (samp) begin
            data[bidx] <= line_s;
            par_acc    <= par_acc ^ line_s;
            all_low    <= all_low & low_now;
            if (bidx == 3'd4 + {1'b0, wlen}) state <= par_en ? S_PAR : S_STOP;
            else bidx <= bidx + 1'b1;
          end
        end
        S_PAR: if (tick) begin
          cnt <= cnt + 1'b1;
          if (samp) begin
            par_acc <= par_acc ^ line_s;
            all_low <= all_low & low_now;
            state   <= S_STOP;
          end
        end
        S_STOP: if (tick) begin
          cnt <= cnt + 1'b1;
          if (samp) begin
            if (stop_left) begin
              stop_left <= 1'b0;
              frm       <= fin_ferr;
              all_low   <= fin_all;
            end else begin
              push <= 1'b1;
              if (fin_all) word <= '{brk: 1'b1, ovr: 1'b0, perr: 1'b0, ferr: 1'b0, data: 8'h00};
              else         word <= '{brk: 1'b0, ovr: 1'b0, perr: fin_perr, ferr: fin_ferr, data: data};
              state <= low_now ? S_HOLD : S_IDLE;
            end
          end
        end
        S_HOLD: if (!low_now) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uartrx_store.sv
module uartrx_store
  import uartrx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              push,
  input  rx_word_t          push_word,
  input  logic              rd_ok,
  output rx_word_t          rd_word,
  output logic [$clog2(DEPTH):0] occ
);
  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  ovf;
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       cap;
  logic              full, wr_ok, ovr_set;

  assign cap     = fifo_en ? (AW+1)'(DEPTH) : (AW+1)'(1);
  assign full    = (occ >= cap);
  assign wr_ok   = push && (!full || rd_ok);
  assign ovr_set = push && full && !rd_ok;

  // Storage array without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; occ <= '0; ovf <= '0; rd_word <= '0;
    end else begin
      if (wr_ok) begin
        wp      <= wp + 1'b1;
        ovf[wp] <= 1'b0;
      end
      if (ovr_set) ovf[wp - 1'b1] <= 1'b1;
      if (rd_ok) begin
        rp      <= rp + 1'b1;
        rd_word <= mem[rp] | (WORD_W'(ovf[rp]) << 10);
      end
      occ <= occ + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
    end
  end
endmodule

// File: rtl/uartrx_idle_timer.sv
module uartrx_idle_timer #(
  parameter int OSR      = 16,
  parameter int TMO_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  input  logic kick,
  output logic irq
);
  localparam int LIMIT = OSR * TMO_BITS;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || kick || !active) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (tick && cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
      if (cnt == CW'(LIMIT)) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_efifo.sv
module uart_rx_efifo
  import uartrx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int OSR      = 16,
  parameter int TMO_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_line,
  input  logic        tick16,
  input  logic [1:0]  cfg_wlen,
  input  logic        cfg_par_en,
  input  logic        cfg_par_even,
  input  logic        cfg_stop2,
  input  logic        cfg_fifo_en,
  input  logic        rd_en,
  output logic [11:0] rd_word,
  output logic        rx_empty,
  output logic        irq_rx,
  output logic        irq_tmo
);
  localparam int AW = $clog2(DEPTH);

  logic        fr_push;
  rx_word_t    fr_word;
  rx_word_t    q_word;
  logic [AW:0] occ;
  logic        rd_ok;

  assign rd_ok = rd_en && (occ != '0);

  uartrx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst(rst), .tick(tick16), .line(rx_line),
    .wlen(cfg_wlen), .par_en(cfg_par_en), .par_even(cfg_par_even),
    .stop2(cfg_stop2), .push(fr_push), .word(fr_word)
  );

  uartrx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .fifo_en(cfg_fifo_en), .push(fr_push),
    .push_word(fr_word), .rd_ok(rd_ok), .rd_word(q_word), .occ(occ)
  );

  uartrx_idle_timer #(.OSR(OSR), .TMO_BITS(TMO_BITS)) u_tmo (
    .clk(clk), .rst(rst), .tick(tick16), .active(occ != '0),
    .kick(fr_push || rd_ok), .irq(irq_tmo)
  );

  assign rd_word  = q_word;
  assign rx_empty = (occ == '0);
  assign irq_rx   = cfg_fifo_en ? (occ >= (AW+1)'(DEPTH / 2)) : (occ != '0);
endmodule

// File: rtl/uart_rx_efifo_chk.sv
module uart_rx_efifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   rd_en,
  input logic                   rx_empty,
  input logic                   irq_rx,
  input logic                   irq_tmo,
  input logic [11:0]            rd_word,
  input logic [$clog2(DEPTH):0] occ,
  input logic                   push,
  input logic [11:0]            push_word
);
  // R9 / R10: no level request while nothing is stored
  a_r10_no_irq_when_empty: assert property (@(posedge clk) disable iff (rst)
    rx_empty |-> !irq_rx);

  // R11: idle request only while words wait
  a_r11_tmo_needs_data: assert property (@(posedge clk) disable iff (rst)
    irq_tmo |-> !rx_empty);

  // R8: read of an empty queue leaves the word alone
  a_r8_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rx_empty) |=> $stable(rd_word));

  // R6: stored count never exceeds capacity
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= ($clog2(DEPTH)+1)'(DEPTH));

  // R5: a break entry carries no framing, parity or data
  a_r5_break_clean: assert property (@(posedge clk) disable iff (rst)
    (push && push_word[11]) |-> (push_word[9:0] == 10'd0));
endmodule

bind uart_rx_efifo uart_rx_efifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rx_empty(rx_empty),
  .irq_rx(irq_rx), .irq_tmo(irq_tmo), .rd_word(rd_word), .occ(occ),
  .push(fr_push), .push_word(fr_word)
);

// File: tb/sim_uart_rx_efifo.sv
module sim_uart_rx_efifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_line = 1'b1;
  logic        tick16 = 1'b0;
  logic [1:0]  cfg_wlen = 2'b11;
  logic        cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_stop2 = 1'b0;
  logic        cfg_fifo_en = 1'b1;
  logic        rd_en = 1'b0;
  logic [11:0] rd_word;
  logic        rx_empty, irq_rx, irq_tmo;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  localparam int BITCLK = 64;   // 16 ticks of 4 clocks each
  logic [11:0] q[$];

  always #2.5 clk = ~clk;       // 200 MHz

  uart_rx_efifo u0 (
    .clk(clk), .rst(rst), .rx_line(rx_line), .tick16(tick16),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop2(cfg_stop2), .cfg_fifo_en(cfg_fifo_en), .rd_en(rd_en),
    .rd_word(rd_word), .rx_empty(rx_empty), .irq_rx(irq_rx), .irq_tmo(irq_tmo)
  );

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      tick16 = (div == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_word(input logic [7:0] ch, input int nb,
                                           input bit pen, input bit badp, input bit bads);
    logic [7:0] m = 8'((1 << nb) - 1);
    return {2'b00, pen & badp, bads, ch & m};
  endfunction

  task automatic bit_out(input logic b);
    rx_line = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] ch, input int nb, input bit pen,
                            input bit ev, input bit st2, input bit badp, input bit bads);
    logic p = 1'b0;
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) begin
      bit_out(ch[i]);
      p = p ^ ch[i];
    end
    if (pen) bit_out((ev ? p : ~p) ^ badp);
    bit_out(!bads);
    if (st2) bit_out(1'b1);
    rx_line = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic model_push(input logic [11:0] w, input int cap);
    if (q.size() < cap) q.push_back(w);
    else q[q.size()-1] = q[q.size()-1] | 12'h400;
  endtask

  task automatic read_one(output logic [11:0] w);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    w = rd_word;
  endtask

  task automatic drain(input string tag);
    logic [11:0] w;
    while (q.size() > 0) begin
      read_one(w);
      chk(tag, w, q.pop_front());
    end
    chk({tag, " R9 empty after drain"}, rx_empty, 1);
  endtask

  task automatic set_cfg(input int nb, input bit pen, input bit ev, input bit st2);
    cfg_wlen = 2'(nb - 5); cfg_par_en = pen; cfg_par_even = ev; cfg_stop2 = st2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] w, last;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 empty", rx_empty, 1);
    chk("R12 irq_rx", irq_rx, 0);
    chk("R12 irq_tmo", irq_tmo, 0);
    chk("R12 rd_word", rd_word, 0);

    // R1 R2 R4 R6: random frame formats, data and injected errors
    for (int b = 0; b < 12; b++) begin
      int nb = 5 + int'($urandom % 4);
      bit pen = $urandom % 2, ev = $urandom % 2, st2 = $urandom % 2;
      int n = 1 + int'($urandom % 6);
      set_cfg(nb, pen, ev, st2);
      cfg_fifo_en = 1'b1;
      for (int k = 0; k < n; k++) begin
        logic [7:0] ch = 8'($urandom);
        bit badp = pen && ($urandom % 5 == 0);
        bit bads = ($urandom % 6 == 0);
        send_frame(ch, nb, pen, ev, st2, badp, bads);
        model_push(exp_word(ch, nb, pen, badp, bads), 16);
      end
      drain("R1 R2 R4 R6 word");
    end

    // R3 glitch: low for 2 ticks only
    set_cfg(8, 0, 0, 0);
    rx_line = 1'b0; repeat (8) @(negedge clk);
    rx_line = 1'b1; repeat (200) @(negedge clk);
    chk("R3 glitch stores nothing", rx_empty, 1);
    send_frame(8'hA5, 8, 0, 0, 0, 0, 0);
    model_push(12'h0A5, 16);
    drain("R3 frame after glitch");

    // R5 break: low for a whole 8E2 frame plus extra
    set_cfg(8, 1, 1, 1);
    rx_line = 1'b0; repeat (13 * BITCLK) @(negedge clk);
    rx_line = 1'b1; repeat (BITCLK) @(negedge clk);
    model_push(12'h800, 16);
    drain("R5 break word");
    send_frame(8'h3C, 8, 1, 1, 1, 0, 0);
    model_push(12'h03C, 16);
    drain("R5 recovery after break");

    // R10 level threshold, R6 depth, R7 overrun in queue mode
    set_cfg(8, 0, 0, 0);
    for (int k = 0; k < 7; k++) begin
      send_frame(8'(8'h10 + k), 8, 0, 0, 0, 0, 0);
      model_push(12'(8'h10 + k), 16);
    end
    chk("R10 below half", irq_rx, 0);
    send_frame(8'h17, 8, 0, 0, 0, 0, 0);
    model_push(12'h017, 16);
    chk("R10 at half", irq_rx, 1);
    for (int k = 8; k < 17; k++) begin
      send_frame(8'(8'h10 + k), 8, 0, 0, 0, 0, 0);
      model_push(12'(8'h10 + k), 16);
    end
    chk("R6 holds 16", q.size(), 16);
    chk("R7 last flagged", q[15], 12'h41F);
    drain("R6 R7 queue order");

    // R8 read while empty
    last = rd_word;
    read_one(w);
    chk("R8 empty read keeps word", w, last);
    chk("R8 still empty", rx_empty, 1);

    // R6 R7 R10 single-entry mode
    cfg_fifo_en = 1'b0;
    send_frame(8'h81, 8, 0, 0, 0, 0, 0);
    model_push(12'h081, 1);
    chk("R10 single entry irq", irq_rx, 1);
    send_frame(8'h82, 8, 0, 0, 0, 0, 0);
    model_push(12'h082, 1);
    drain("R6 R7 single entry overrun");
    chk("R10 irq clears", irq_rx, 0);

    // R11 timeout
    cfg_fifo_en = 1'b1;
    send_frame(8'h55, 8, 0, 0, 0, 0, 0);
    model_push(12'h055, 16);
    repeat (1800) @(negedge clk);
    chk("R11 not yet", irq_tmo, 0);
    repeat (400) @(negedge clk);
    chk("R11 timeout raised", irq_tmo, 1);
    read_one(w);
    chk("R11 data", w, q.pop_front());
    chk("R11 cleared by read", irq_tmo, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule